// File: doc/BRIEF.md
# Streaming Bit-Width Gearbox

This block repacks a valid/ready stream of `IN_W`-bit words into a valid/ready stream of `OUT_W`-bit words. The two widths are free parameters and need not divide one another: a 3-bit source can feed a 7-bit sink, and bits left over from one output word carry into the next. Bits keep their order. The lowest bit of the first input word becomes the lowest bit of the first output word, and later input bits take the next higher positions.

Each input word may carry an end-of-packet marker. The output word that holds the final bit of a marked input word leaves with the marker set, and every earlier output word leaves with it clear. If the packet ends part-way through an output word, that word is sent with zeros in its unused upper bits. The next packet then starts again at bit 0 of a fresh output word. Both sides may stall at any time. The output is held in a register and stays unchanged until the sink takes it.

Top module: `stream_gearbox`

## Requirements
- R1: Packing is least-significant-first. Bit 0 of the first input word after reset appears at bit 0 of the first output word, and each later input bit lands one position higher, wrapping into the next output word.
- R2: When narrowing, each input word leaves as consecutive output words, lowest chunk first. For 16 to 4, input 0x3210 yields 0x0, 0x1, 0x2, 0x3.
- R3: Non-integer ratios carry leftover bits across words. For 3 to 7, the inputs 001, 010, 100, 011, 110, 111, 000 (binary) yield 0010001, 1001110 and 0001111.
- R4: Once `out_valid` is high it stays high, with `out_data` and `out_last` unchanged, until a cycle in which `out_ready` is high.
- R5: The internal store holds `IN_W+OUT_W` bits. `in_ready` is high only when no marked word is still pending and the bits held after this cycle's output load, plus `IN_W`, fit in that store. An input accept and an output load may happen in the same cycle. For 3 to 7 with `out_ready` held low, five words are accepted and then `in_ready` stays low.
- R6: `out_last` is 1 only on the output word holding the final bit of a marked input word. For 16 to 4, a marked input gives flags 0, 0, 0, 1. While a marked word is still being emitted, no further input is accepted.
- R7: A packet that ends part-way through an output word is flushed zero-padded with `out_last`=1. For 3 to 7, the marked pair 101, 011 gives 0011101. The next input then starts at bit 0 of a new output word.
- R8: Under random stalls on both sides, no word and no marker is lost or duplicated. For 16 to 4, 50 inputs with every fifth one marked give 200 outputs in order, exactly 10 of them flagged.
- R9: A synchronous active-high reset empties the store, clears the pending marker and drops `out_valid`. After reset `in_ready` is high.
- R10: The packing composes. A 12-to-48 gearbox feeding a 48-to-64 gearbox produces the same 64-bit words as a direct 12-to-64 gearbox given the same input.

Top module ports (in port-list order):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Gearbox takes the offered word at this edge |
| in_data | input | IN_W | Input word |
| in_last | input | 1 | Input word ends a packet |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Sink takes the output word at this edge |
| out_data | output | OUT_W | Output word |
| out_last | output | 1 | Output word ends a packet |

## Verification
The bench drives a 3-to-7 ratio with fixed vectors. A design that shifted leftovers the wrong way, or dropped carried bits, would scramble the second and third words. It checks a packet flush that ends mid-word: a missing zero-pad or a stale fill count would leak old bits, or shift the next packet off bit 0. It fills the store against a stalled sink and counts accepted words: an off-by-one in the space check would take a sixth word and overwrite bits. Random two-sided stalls on a 16-to-4 narrowing, plus a chained-versus-direct comparison at 12/48/64, expose lost or doubled words and markers raised on the wrong chunk.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  // number of bits an output load removes from a store holding `fill` bits
  function automatic int unsigned gbx_take(input int unsigned fill, input int unsigned out_w);
    return (fill >= out_w) ? out_w : fill;
  endfunction

endpackage

// File: rtl/gbx_residue.sv
module gbx_residue
  import gbx_pkg::*;
#(
  parameter int unsigned IN_W  = 3,
  parameter int unsigned OUT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_last,
  input  logic             slot_free,
  output logic             pop,
  output logic [OUT_W-1:0] pop_data,
  output logic             pop_last
);

  localparam int unsigned RW    = IN_W + OUT_W;
  localparam int unsigned CNT_W = $clog2(RW + 1);
  localparam int unsigned ROOM  = RW - IN_W;

  logic [RW-1:0]    store_q;
  logic [CNT_W-1:0] fill_q;
  logic             pend_q;

  logic             have_word;
  logic [CNT_W-1:0] take;
  logic [CNT_W-1:0] fill_mid;
  logic             acc;
  logic [RW-1:0]    shifted;
  logic [RW-1:0]    incoming;

  always_comb begin
    have_word = (fill_q >= CNT_W'(OUT_W)) || (pend_q && (fill_q != '0));
    pop       = slot_free && have_word;
    take      = CNT_W'(gbx_take(int'(fill_q), OUT_W));
    pop_last  = pend_q && (fill_q <= CNT_W'(OUT_W));
    pop_data  = store_q[OUT_W-1:0];
    fill_mid  = pop ? (fill_q - take) : fill_q;
    in_ready  = !pend_q && (fill_mid <= CNT_W'(ROOM));
    acc       = in_valid && in_ready;
    shifted   = pop ? (store_q >> OUT_W) : store_q;
    incoming  = acc ? (RW'(in_data) << fill_mid) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      fill_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      store_q <= shifted | incoming;
      fill_q  <= acc ? (fill_mid + CNT_W'(IN_W)) : fill_mid;
      if (acc && in_last)
        pend_q <= 1'b1;
      else if (pop && pop_last)
        pend_q <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CNT_W'(RW)); // R5

  AST_MARK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (acc && in_last) |=> !in_ready); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop && pop_last) |=> (fill_q == '0)); // R7

endmodule

// File: rtl/gbx_out_reg.sv
module gbx_out_reg #(
  parameter int unsigned OUT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic [OUT_W-1:0] pop_data,
  input  logic             pop_last,
  output logic             slot_free,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_data  <= pop_data;
      out_last  <= pop_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R4

  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
    pop |-> (!out_valid || out_ready)); // R4

endmodule

// File: rtl/stream_gearbox.sv
module stream_gearbox #(
  parameter int unsigned IN_W  = 3,
  parameter int unsigned OUT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last
);

  logic             slot_free;
  logic             pop;
  logic [OUT_W-1:0] pop_data;
  logic             pop_last;

  gbx_residue #(.IN_W(IN_W), .OUT_W(OUT_W)) u_res (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .slot_free(slot_free), .pop(pop), .pop_data(pop_data), .pop_last(pop_last)
  );

  gbx_out_reg #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst),
    .pop(pop), .pop_data(pop_data), .pop_last(pop_last), .slot_free(slot_free),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid); // R9

endmodule

// File: tb/stream_gearbox_tb.sv
module stream_gearbox_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // 3 -> 7 main instance
  logic       d_iv = 0, d_il = 0, d_ordy = 1;
  logic [2:0] d_id = '0;
  logic       d_ir, d_ov, d_ol;
  logic [6:0] d_od;

  stream_gearbox #(.IN_W(3), .OUT_W(7)) u_dut (
    .clk(clk), .rst(rst), .in_valid(d_iv), .in_ready(d_ir), .in_data(d_id), .in_last(d_il),
    .out_valid(d_ov), .out_ready(d_ordy), .out_data(d_od), .out_last(d_ol));

  // 16 -> 4 narrowing instance
  logic        n_iv = 0, n_il = 0, n_ordy = 1;
  logic [15:0] n_id = '0;
  logic        n_ir, n_ov, n_ol;
  logic [3:0]  n_od;

  stream_gearbox #(.IN_W(16), .OUT_W(4)) u_nar (
    .clk(clk), .rst(rst), .in_valid(n_iv), .in_ready(n_ir), .in_data(n_id), .in_last(n_il),
    .out_valid(n_ov), .out_ready(n_ordy), .out_data(n_od), .out_last(n_ol));

  // chain 12 -> 48 -> 64 versus direct 12 -> 64
  logic        a_iv = 0, b_iv = 0;
  logic [11:0] a_id = '0, b_id = '0;
  logic        a_ir, b_ir, m_v, m_r, m_l, c2_v, c2_l, c3_v, c3_l;
  logic [47:0] m_d;
  logic [63:0] c2_d, c3_d;

  stream_gearbox #(.IN_W(12), .OUT_W(48)) u_c1 (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir), .in_data(a_id), .in_last(1'b0),
    .out_valid(m_v), .out_ready(m_r), .out_data(m_d), .out_last(m_l));
  stream_gearbox #(.IN_W(48), .OUT_W(64)) u_c2 (
    .clk(clk), .rst(rst), .in_valid(m_v), .in_ready(m_r), .in_data(m_d), .in_last(m_l),
    .out_valid(c2_v), .out_ready(1'b1), .out_data(c2_d), .out_last(c2_l));
  stream_gearbox #(.IN_W(12), .OUT_W(64)) u_c3 (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir), .in_data(b_id), .in_last(1'b0),
    .out_valid(c3_v), .out_ready(1'b1), .out_data(c3_d), .out_last(c3_l));

  // capture of output transfers, sampled mid-cycle
  logic [6:0]  dcap [16];
  logic        dlst [16];
  int          dn = 0;
  logic [3:0]  ncap [256];
  logic        nlst [256];
  int          nn = 0;
  logic [63:0] c2cap [4];
  logic [63:0] c3cap [4];
  int          c2n = 0, c3n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (d_ov && d_ordy && dn < 16) begin dcap[dn] = d_od; dlst[dn] = d_ol; dn++; end
      if (n_ov && n_ordy && nn < 256) begin ncap[nn] = n_od; nlst[nn] = n_ol; nn++; end
      if (c2_v && c2n < 4) begin c2cap[c2n] = c2_d; c2n++; end
      if (c3_v && c3n < 4) begin c3cap[c3n] = c3_d; c3n++; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic d_send(input logic [2:0] v, input logic l);
    d_iv = 1; d_id = v; d_il = l;
    do @(negedge clk); while (!d_ir);
    @(posedge clk); #1;
    d_iv = 0; d_il = 0;
  endtask

  task automatic n_send(input logic [15:0] v, input logic l);
    n_iv = 1; n_id = v; n_il = l;
    do @(negedge clk); while (!n_ir);
    @(posedge clk); #1;
    n_iv = 0; n_il = 0;
  endtask

  task automatic a_send(input logic [11:0] v);
    a_iv = 1; a_id = v;
    do @(negedge clk); while (!a_ir);
    @(posedge clk); #1;
    a_iv = 0;
  endtask

  task automatic b_send(input logic [11:0] v);
    b_iv = 1; b_id = v;
    do @(negedge clk); while (!b_ir);
    @(posedge clk); #1;
    b_iv = 0;
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(d_ov == 1'b0, "R9 out_valid after reset", 64'(d_ov), 64'd0);
    chk(d_ir == 1'b1, "R9 in_ready after reset", 64'(d_ir), 64'd1);
    chk(n_ov == 1'b0, "R9 narrow out_valid after reset", 64'(n_ov), 64'd0);
    @(posedge clk); #1;
  endtask

  task automatic t_ratio;
    logic [6:0] exp [3];
    exp[0] = 7'b0010001; exp[1] = 7'b1001110; exp[2] = 7'b0001111;
    dn = 0;
    d_send(3'b001, 0); d_send(3'b010, 0); d_send(3'b100, 0); d_send(3'b011, 0);
    d_send(3'b110, 0); d_send(3'b111, 0); d_send(3'b000, 0);
    settle(6);
    chk(dn == 3, "R3 output count 3 to 7", 64'(dn), 64'd3);
    chk(dcap[0] == exp[0], "R1 first word low bits", 64'(dcap[0]), 64'(exp[0]));
    for (int i = 1; i < 3; i++)
      chk(dcap[i] == exp[i], "R3 carried leftover bits", 64'(dcap[i]), 64'(exp[i]));
  endtask

  task automatic t_flush;
    dn = 0;
    d_send(3'b101, 0); d_send(3'b011, 1);
    settle(6);
    chk(dn == 1, "R7 one padded word", 64'(dn), 64'd1);
    chk(dcap[0] == 7'b0011101, "R7 zero padded data", 64'(dcap[0]), 64'b0011101);
    chk(dlst[0] == 1'b1, "R7 flag on padded word", 64'(dlst[0]), 64'd1);
    dn = 0;
    d_send(3'b001, 0); d_send(3'b010, 0); d_send(3'b100, 0);
    d_send(3'b011, 0); d_send(3'b110, 0);
    settle(6);
    chk(dn == 2, "R7 next packet count", 64'(dn), 64'd2);
    chk(dcap[0] == 7'b0010001, "R7 next packet starts at bit 0", 64'(dcap[0]), 64'b0010001);
    chk(dlst[0] == 1'b0, "R6 flag clear on unmarked", 64'(dlst[0]), 64'd0);
    d_send(3'b111, 0); d_send(3'b000, 0);
    settle(6);
  endtask

  task automatic t_backpressure;
    int accepted = 0;
    logic [6:0] held;
    dn = 0;
    d_ordy = 0;
    d_iv = 1; d_id = 3'b001; d_il = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (d_ir) accepted++;
      @(posedge clk); #1;
    end
    d_iv = 0;
    @(negedge clk);
    chk(accepted == 5, "R5 words accepted while stalled", 64'(accepted), 64'd5);
    chk(d_ir == 1'b0, "R5 in_ready low when full", 64'(d_ir), 64'd0);
    chk(d_ov == 1'b1, "R4 output valid while stalled", 64'(d_ov), 64'd1);
    held = d_od;
    chk(held == 7'b1001001, "R4 held output value", 64'(held), 64'b1001001);
    repeat (3) @(negedge clk);
    chk(d_ov == 1'b1 && d_od == held, "R4 output stable under stall", 64'(d_od), 64'(held));
    @(posedge clk); #1;
    d_ordy = 1;
    settle(6);
    chk(dn == 2, "R5 drained words", 64'(dn), 64'd2);
  endtask

  task automatic t_narrow;
    nn = 0;
    n_send(16'h3210, 0);
    n_send(16'h4321, 1);
    settle(8);
    chk(nn == 8, "R2 narrow output count", 64'(nn), 64'd8);
    for (int i = 0; i < 4; i++)
      chk(ncap[i] == 4'(i), "R2 lowest chunk first", 64'(ncap[i]), 64'(i));
    for (int i = 0; i < 4; i++) begin
      chk(ncap[4+i] == 4'(i + 1), "R6 marked word data", 64'(ncap[4+i]), 64'(i + 1));
      chk(nlst[4+i] == (i == 3), "R6 flag only on final chunk", 64'(nlst[4+i]), 64'(i == 3));
    end
  endtask

  task automatic t_stall;
    int bad = 0, nlast = 0, badlast = 0;
    nn = 0;
    fork
      begin
        for (int w = 0; w < 50; w++) begin
          n_send({4'(4*w+3), 4'(4*w+2), 4'(4*w+1), 4'(4*w)}, (w % 5) == 0);
          if ($urandom_range(0, 2) == 0) begin @(posedge clk); #1; end
        end
      end
      begin
        for (int c = 0; c < 3000 && nn < 200; c++) begin
          @(posedge clk); #1;
          n_ordy = ($urandom_range(0, 3) != 0);
        end
        n_ordy = 1;
      end
    join
    settle(8);
    chk(nn == 200, "R8 no loss or duplication count", 64'(nn), 64'd200);
    for (int k = 0; k < 200; k++) begin
      if (ncap[k] != 4'(k)) bad++;
      if (nlst[k]) nlast++;
      if (nlst[k] != (((k / 4) % 5 == 0) && (k % 4 == 3))) badlast++;
    end
    chk(bad == 0, "R8 data order under stalls", 64'(bad), 64'd0);
    chk(nlast == 10, "R8 marker count", 64'(nlast), 64'd10);
    chk(badlast == 0, "R8 marker positions", 64'(badlast), 64'd0);
  endtask

  task automatic t_chain;
    logic [11:0]  w [16];
    logic [191:0] all;
    all = '0;
    for (int i = 0; i < 16; i++) begin
      w[i] = 12'($urandom);
      all = all | (192'(w[i]) << (12 * i));
    end
    c2n = 0; c3n = 0;
    fork
      begin for (int i = 0; i < 16; i++) a_send(w[i]); end
      begin for (int i = 0; i < 16; i++) b_send(w[i]); end
    join
    settle(10);
    chk(c2n == 3 && c3n == 3, "R10 chain output count", 64'(c2n), 64'd3);
    for (int k = 0; k < 3; k++) begin
      chk(c3cap[k] == all[64*k +: 64], "R10 direct path data", c3cap[k], all[64*k +: 64]);
      chk(c2cap[k] == c3cap[k], "R10 chained equals direct", c2cap[k], c3cap[k]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_ratio();
    t_flush();
    t_narrow();
    t_stall();
    t_chain();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule